// File: doc/BRIEF.md
# Vector Prefix Legality Trap Checker

This decode-stage checker sits beside the decoder of a small scalar core that also accepts 64-bit prefixed instructions. For each decoded instruction it decides whether the core may run it as an ordinary scalar operation or must take an illegal-instruction trap. The prefix carries a 24-bit mode field. The hardware supports only the subset that reduces to plain scalar behaviour: a vector length of at most one, cleared vector state, no element-width override, and integer predication from a few fixed registers. Anything beyond that subset is left to a software trap handler.

The decoder presents one instruction per cycle with `insn_valid`. One clock edge later the checker shows its verdict on `exec_scalar` or `trap_req` for exactly one cycle, together with the trap vector offset. A pipeline flush cancels the verdict due in the next cycle. The checker executes nothing itself.

Top module: `vpx_legality`

## Requirements
- R1: An instruction with `is_prefixed`=0, `op_class`=0 and no special-register request never traps, whatever the mode field, vector length, vector state, predicate register or `rc_bit`/`cr_idx` values.
- R2: A prefixed instruction of class 0 with an all-zero mode field, all-zero `vstate`, `vec_len` of 0 or 1 and `rc_bit`=0 runs as scalar and does not trap.
- R3: A prefixed instruction with a nonzero element-width field (mode bits 21:20) traps.
- R4: A prefixed instruction with `vec_len` greater than 1 traps. A vector length of 1 does not trap for this reason.
- R5: While `trap_req` is high, `trap_vec` is 0x700. Otherwise `trap_vec` is 0.
- R6: A special-register request for numbers 704 to 719 traps unless the number is 704 or 705, which are implemented. This holds for prefixed and unprefixed instructions alike. Numbers outside 704 to 719 never trap.
- R7: Predicate kind is held in mode bits 23:22: 00 means none, 01 single integer, 10 twin integer, 11 condition-field. Kinds 01 and 10 are accepted when `pred_reg` is 3, 10 or 30 and trap for any other register. Kind 11 always traps.
- R8: A prefixed instruction with `rc_bit`=1 and `cr_idx` of 8 or more traps. With `cr_idx` of 7 or less, or with `rc_bit`=0, it does not trap for this reason.
- R9: `op_class` 1 (set vector length) runs without a trap. Classes 2 to 7, the unimplemented vector-control instructions, always trap, prefixed or not.
- R10: The verdict for an instruction presented with `insn_valid` high appears in the cycle after the clock edge that samples it and lasts one cycle. `exec_scalar` and `trap_req` are never high together. A cycle with `insn_valid` low yields both outputs low in the next cycle. After reset all outputs are 0.
- R11: `flush` high at a clock edge forces `exec_scalar`, `trap_req` and `trap_vec` to 0 in the next cycle, even when `insn_valid` is high at that edge.
- R12: A prefixed instruction traps when `vstate` is nonzero or when any mode bit in 19:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancels the verdict due next cycle |
| insn_valid | input | 1 | An instruction is being decoded this cycle |
| is_prefixed | input | 1 | The instruction carries the vector prefix |
| op_class | input | 3 | 0 ordinary, 1 set vector length, 2-7 other vector-control |
| mode_fld | input | 24 | Prefix mode field |
| vec_len | input | VL_W | Current vector length |
| vstate | input | VS_W | Remaining vector-state register contents |
| pred_reg | input | 5 | Integer predicate source register number |
| rc_bit | input | 1 | Record bit of the instruction |
| cr_idx | input | CR_W | Target condition-field index of the co-result |
| spr_req | input | 1 | Instruction reads or writes a special register |
| spr_num | input | SPR_W | Special register number |
| exec_scalar | output | 1 | Run as plain scalar hardware |
| trap_req | output | 1 | Raise the illegal-instruction trap |
| trap_vec | output | OFF_W | Trap vector offset |

## Verification
Every verdict is due exactly one rising edge after its stimulus. The bench drives inputs on the falling edge and samples outputs on the following falling edge, which places each sample in the only cycle where the verdict is valid. The hold and flush checks look one further cycle on, after `insn_valid` has dropped or `flush` has been applied, and expect both outputs low there.

// File: rtl/vpx_legality.sv
module vpx_legality #(
  parameter int VL_W     = 7,
  parameter int VS_W     = 16,
  parameter int CR_W     = 7,
  parameter int NUM_CR   = 8,
  parameter int SPR_W    = 10,
  parameter int CTX_BASE = 704,
  parameter int CTX_SPAN = 16,
  parameter int CTX_IMPL = 2,
  parameter int OFF_W    = 12,
  parameter logic [OFF_W-1:0] TRAP_OFF = 12'h700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             insn_valid,
  input  logic             is_prefixed,
  input  logic [2:0]       op_class,
  input  logic [23:0]      mode_fld,
  input  logic [VL_W-1:0]  vec_len,
  input  logic [VS_W-1:0]  vstate,
  input  logic [4:0]       pred_reg,
  input  logic             rc_bit,
  input  logic [CR_W-1:0]  cr_idx,
  input  logic             spr_req,
  input  logic [SPR_W-1:0] spr_num,
  output logic             exec_scalar,
  output logic             trap_req,
  output logic [OFF_W-1:0] trap_vec
);

  localparam logic [SPR_W:0] CTX_LO   = (SPR_W+1)'(CTX_BASE);
  localparam logic [SPR_W:0] CTX_HI   = (SPR_W+1)'(CTX_BASE + CTX_SPAN);
  localparam logic [SPR_W:0] CTX_OK   = (SPR_W+1)'(CTX_BASE + CTX_IMPL);
  localparam logic [CR_W-1:0] CR_LIM  = CR_W'(NUM_CR);
  localparam logic [VL_W-1:0] VL_ONE  = VL_W'(1);

  logic [SPR_W:0] spr_x;
  logic [1:0]     pred_kind;
  logic           pred_reg_ok, bad_pred, bad_ew, bad_mode;
  logic           bad_len, bad_state, bad_cr, bad_op, bad_spr;
  logic           pfx_bad, trap_now;

  assign spr_x       = {1'b0, spr_num};
  assign pred_kind   = mode_fld[23:22];
  assign pred_reg_ok = (pred_reg == 5'd3) || (pred_reg == 5'd10) || (pred_reg == 5'd30);

  assign bad_pred  = (pred_kind == 2'b11) || ((pred_kind != 2'b00) && !pred_reg_ok);
  assign bad_ew    = |mode_fld[21:20];
  assign bad_mode  = |mode_fld[19:0];
  assign bad_len   = vec_len > VL_ONE;
  assign bad_state = |vstate;
  assign bad_cr    = rc_bit && (cr_idx >= CR_LIM);

  assign pfx_bad = is_prefixed &&
                   (bad_pred || bad_ew || bad_mode || bad_len || bad_state || bad_cr);

  assign bad_op  = op_class >= 3'd2;
  assign bad_spr = spr_req && (spr_x >= CTX_OK) && (spr_x < CTX_HI) && (spr_x >= CTX_LO);

  assign trap_now = pfx_bad || bad_op || bad_spr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_scalar <= 1'b0;
      trap_req    <= 1'b0;
      trap_vec    <= '0;
    end else if (flush || !insn_valid) begin
      exec_scalar <= 1'b0;
      trap_req    <= 1'b0;
      trap_vec    <= '0;
    end else begin
      exec_scalar <= !trap_now;
      trap_req    <= trap_now;
      trap_vec    <= trap_now ? TRAP_OFF : '0;
    end
  end

endmodule

// File: rtl/vpx_legality_chk.sv
module vpx_legality_chk #(
  parameter int VL_W  = 7,
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] TRAP_OFF = 12'h700
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             insn_valid,
  input logic             is_prefixed,
  input logic [2:0]       op_class,
  input logic             spr_req,
  input logic [VL_W-1:0]  vec_len,
  input logic             exec_scalar,
  input logic             trap_req,
  input logic [OFF_W-1:0] trap_vec
);

  a_r5_offset_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_vec == TRAP_OFF);

  a_r5_offset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_vec == '0);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && exec_scalar));

  a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !trap_req && !exec_scalar);

  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !trap_req && !exec_scalar && trap_vec == '0);

  a_r1_plain_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !flush && !is_prefixed && op_class == 3'd0 && !spr_req |=> exec_scalar);

  a_r4_long_vector: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !flush && is_prefixed && vec_len > VL_W'(1) |=> trap_req);

  a_r9_vector_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !flush && op_class >= 3'd2 |=> trap_req);

endmodule

bind vpx_legality vpx_legality_chk #(.VL_W(VL_W), .OFF_W(OFF_W), .TRAP_OFF(TRAP_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .insn_valid(insn_valid),
  .is_prefixed(is_prefixed), .op_class(op_class), .spr_req(spr_req),
  .vec_len(vec_len), .exec_scalar(exec_scalar), .trap_req(trap_req),
  .trap_vec(trap_vec)
);

// File: tb/sim_vpx_legality.sv
module sim_vpx_legality;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, insn_valid = 1'b0, is_prefixed = 1'b0;
  logic [2:0] op_class = '0;
  logic [23:0] mode_fld = '0;
  logic [6:0] vec_len = '0;
  logic [15:0] vstate = '0;
  logic [4:0] pred_reg = '0;
  logic rc_bit = 1'b0;
  logic [6:0] cr_idx = '0;
  logic spr_req = 1'b0;
  logic [9:0] spr_num = '0;
  logic exec_scalar, trap_req;
  logic [11:0] trap_vec;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  vpx_legality u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .insn_valid(insn_valid),
    .is_prefixed(is_prefixed), .op_class(op_class), .mode_fld(mode_fld),
    .vec_len(vec_len), .vstate(vstate), .pred_reg(pred_reg), .rc_bit(rc_bit),
    .cr_idx(cr_idx), .spr_req(spr_req), .spr_num(spr_num),
    .exec_scalar(exec_scalar), .trap_req(trap_req), .trap_vec(trap_vec)
  );

  typedef struct packed {
    logic        pfx;
    logic [2:0]  cls;
    logic [23:0] mode;
    logic [6:0]  vl;
    logic [15:0] vst;
    logic [4:0]  preg;
    logic        rc;
    logic [6:0]  cr;
    logic        sreq;
    logic [9:0]  snum;
    logic        trap;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 24'hFFFFFF, 7'd9, 16'h0005, 5'd4,  1'b1, 7'd100, 1'b0, 10'd0,   1'b0, 4'd1},  // R1
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd2},  // R2
    '{1'b1, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd2},  // R2
    '{1'b1, 3'd0, 24'h100000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd3},  // R3
    '{1'b1, 3'd0, 24'h200000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd3},  // R3
    '{1'b1, 3'd0, 24'h000000, 7'd4, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd4},  // R4
    '{1'b1, 3'd0, 24'h000000, 7'd2, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd4},  // R4
    '{1'b1, 3'd0, 24'h400000, 7'd1, 16'h0000, 5'd3,  1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 24'h800000, 7'd1, 16'h0000, 5'd10, 1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 24'h400000, 7'd1, 16'h0000, 5'd30, 1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 24'h400000, 7'd1, 16'h0000, 5'd4,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd7},  // R7
    '{1'b1, 3'd0, 24'hC00000, 7'd1, 16'h0000, 5'd3,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd7},  // R7
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b1, 7'd7,   1'b0, 10'd0,   1'b0, 4'd8},  // R8
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b1, 7'd8,   1'b0, 10'd0,   1'b1, 4'd8},  // R8
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd100, 1'b0, 10'd0,   1'b0, 4'd8},  // R8
    '{1'b0, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b1, 7'd100, 1'b0, 10'd0,   1'b0, 4'd1},  // R1
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0001, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd12}, // R12
    '{1'b1, 3'd0, 24'h000001, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd12}, // R12
    '{1'b0, 3'd1, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b0, 4'd9},  // R9
    '{1'b0, 3'd2, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd9},  // R9
    '{1'b1, 3'd7, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b0, 10'd0,   1'b1, 4'd9},  // R9
    '{1'b0, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd704, 1'b0, 4'd6},  // R6
    '{1'b0, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd705, 1'b0, 4'd6},  // R6
    '{1'b0, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd706, 1'b1, 4'd6},  // R6
    '{1'b1, 3'd0, 24'h000000, 7'd1, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd719, 1'b1, 4'd6},  // R6
    '{1'b0, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd720, 1'b0, 4'd6},  // R6
    '{1'b0, 3'd0, 24'h000000, 7'd0, 16'h0000, 5'd0,  1'b0, 7'd0,   1'b1, 10'd703, 1'b0, 4'd6}   // R6
  };

  task automatic check(input string tag, input logic ex, input logic tr, input logic [11:0] tv);
    checks++;
    if (exec_scalar !== ex || trap_req !== tr || trap_vec !== tv) begin
      errors++;
      $display("FAIL %s: got exec=%0b trap=%0b vec=%h, expected exec=%0b trap=%0b vec=%h",
               tag, exec_scalar, trap_req, trap_vec, ex, tr, tv);
    end
  endtask

  task automatic drive(input vec_t v);
    is_prefixed = v.pfx; op_class = v.cls; mode_fld = v.mode; vec_len = v.vl;
    vstate = v.vst; pred_reg = v.preg; rc_bit = v.rc; cr_idx = v.cr;
    spr_req = v.sreq; spr_num = v.snum;
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 reset", 1'b0, 1'b0, 12'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      insn_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", TBL[i].rq, i), !TBL[i].trap, TBL[i].trap,
            TBL[i].trap ? 12'h700 : 12'h000);  // R5 offset checked each vector
    end

    // R10: trapping verdict lasts one cycle once insn_valid drops
    drive(TBL[5]);
    insn_valid = 1'b1;
    @(negedge clk);
    check("R10 trap shown", 1'b0, 1'b1, 12'h700);
    insn_valid = 1'b0;
    @(negedge clk);
    check("R10 trap held one cycle", 1'b0, 1'b0, 12'h000);

    // R10: idle input with illegal fields gives no verdict
    drive(TBL[19]);
    @(negedge clk);
    check("R10 idle", 1'b0, 1'b0, 12'h000);

    // R11: flush with a trapping instruction
    insn_valid = 1'b1; flush = 1'b1;
    @(negedge clk);
    check("R11 flush trap", 1'b0, 1'b0, 12'h000);
    // R11: flush with a legal instruction
    drive(TBL[1]);
    @(negedge clk);
    check("R11 flush legal", 1'b0, 1'b0, 12'h000);
    flush = 1'b0;
    @(negedge clk);
    check("R2 after flush", 1'b1, 1'b0, 12'h000);

    // R7 + R4: accepted predicate does not rescue a long vector
    drive(TBL[7]); vec_len = 7'd8;
    @(negedge clk);
    check("R4 predicated long vector", 1'b0, 1'b1, 12'h700);

    insn_valid = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule